// File: doc/BRIEF.md
# Address/Data Breakpoint Comparator Set

This block holds three breakpoint comparators, A, B and C, that watch every valid cycle on a CPU bus and report hits to a trigger controller that sits next to it. Each comparator has its own stored compare value, 17 bits wide by default. Software loads that value one byte at a time: an extended byte, a high byte and a low byte. In the normal mode each comparator checks the bus address against its own value. A per-comparator qualifier can limit the hit to reads or to writes.

Two full modes pair A with B. In these modes B stops looking at the address. It compares one data byte against the low byte of its stored value instead. A's direction qualifier then decides, for both comparators, whether write cycles with the write data bus or read cycles with the read data bus are examined. The block also reports the combined pair result, either "A and B" or "A and not B", as its own pulse.

Comparator C never joins the pairing. It stays a plain third address breakpoint. All hit outputs are registered single-cycle pulses. Each one is gated by the bus-valid strobe and by a global enable.

Top module: `bp_cmp_set`

## Requirements
- R1: After reset all four match outputs are 0 and all three stored compare values are zero.
- R2: A byte write (cfg_we=1) goes to the comparator chosen by cfg_idx (0=A, 1=B, 2=C). cfg_byte chooses the byte: 0 loads bits 16 and up from the low bits of cfg_wdata, 1 loads bits 15:8, and 2 loads bits 7:0. Each byte changes independently of the others. cfg_idx=3 or cfg_byte=3 changes nothing.
- R3: In the normal mode (mode 0, and also the spare code 3), each comparator matches when bus_addr equals its stored value. The match pulse appears in the cycle after the bus cycle and lasts one cycle.
- R4: Direction qualifier: rw_en[i]=1 restricts comparator i to cycles where bus_rd equals rw_dir[i] (1 = read, 0 = write). With rw_en[i]=0 the direction is ignored. Bit 0 belongs to A, bit 1 to B and bit 2 to C.
- R5: No match output is raised for a cycle in which bus_valid or mod_en is 0.
- R6: In the full modes (mode 1 = "A and B", mode 2 = "A and not B"), B matches on the data byte against the low byte of its stored value, and the bus address has no effect on B.
- R7: In the full modes, rw_en[0]=1 together with rw_dir[0]=0 selects write cycles and wr_data. Every other setting selects read cycles and rd_data. rw_en[1] and rw_dir[1] are ignored.
- R8: match_full is A&&B in mode 1 and A&&!B in mode 2, taken on the same bus cycle. It is 0 in the other modes and is never raised without match_a.
- R9: Comparator C compares addresses with its own qualifier in every mode, including the full modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Global enable for all match outputs |
| mode | input | 2 | 0 normal, 1 A and B, 2 A and not B, 3 treated as normal |
| rw_en | input | 3 | Per-comparator direction-qualifier enable (bit0 A, bit1 B, bit2 C) |
| rw_dir | input | 3 | Per-comparator qualifying direction, 1 = read |
| cfg_we | input | 1 | Compare-value byte write strobe |
| cfg_idx | input | 2 | Target comparator of the byte write |
| cfg_byte | input | 2 | Target byte: 0 extended, 1 high, 2 low |
| cfg_wdata | input | 8 | Byte written |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | Core address bus |
| rd_data | input | DATA_W | Read data bus |
| wr_data | input | DATA_W | Write data bus |
| match_a | output | 1 | Comparator A hit pulse |
| match_b | output | 1 | Comparator B hit pulse |
| match_c | output | 1 | Comparator C hit pulse |
| match_full | output | 1 | Combined full-mode pair result pulse |

## Verification
The assertions assume that mode, rw_en and rw_dir stay steady during a bus cycle and are only changed between cycles. They also assume that bus_rd and both data buses carry known values whenever bus_valid is high. The stimulus meets these assumptions in two ways. Every configuration change is made while bus_valid is low, and each bus cycle is a single strobe of one cycle, driven on the falling clock edge with all fields set at once. Byte writes likewise never overlap a bus cycle, so each hit is judged against a fully loaded compare value.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
   typedef enum logic [1:0] {
      BPC_NORMAL  = 2'd0,
      BPC_A_AND_B = 2'd1,
      BPC_A_NOT_B = 2'd2,
      BPC_SPARE   = 2'd3
   } bpc_mode_e;

   localparam int unsigned BPC_NUM_CMP = 3;

   function automatic logic bpc_is_full(input bpc_mode_e m);
      return (m == BPC_A_AND_B) || (m == BPC_A_NOT_B);
   endfunction
endpackage

// File: rtl/bpc_value_regs.sv
module bpc_value_regs #(
   parameter int unsigned ADDR_W  = 17,
   parameter int unsigned NUM_CMP = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [1:0]                      cfg_idx,
   input  logic [1:0]                      cfg_byte,
   input  logic [7:0]                      cfg_wdata,
   output logic [NUM_CMP-1:0][ADDR_W-1:0]  cmp_val
);
   localparam int unsigned EXT_W = ADDR_W - 16;

   if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_width
      $error("bpc_value_regs: ADDR_W must lie in 17..24");
   end
   if (NUM_CMP > 3) begin : g_bad_count
      $error("bpc_value_regs: NUM_CMP must not exceed 3");
   end

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      logic sel;
      assign sel = cfg_we && (cfg_idx == 2'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_val[i] <= '0;
         end else if (sel) begin
            case (cfg_byte)
               2'd0:    cmp_val[i][ADDR_W-1:16] <= cfg_wdata[EXT_W-1:0];
               2'd1:    cmp_val[i][15:8]        <= cfg_wdata;
               2'd2:    cmp_val[i][7:0]         <= cfg_wdata;
               default: ;
            endcase
         end
      end

      // R2: a low-byte write lands, the other bytes hold
      p_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_idx == 2'(i) && cfg_byte == 2'd2) |=>
            (cmp_val[i][7:0] == $past(cfg_wdata)) &&
            (cmp_val[i][ADDR_W-1:8] == $past(cmp_val[i][ADDR_W-1:8])));
      // R2: no write strobe, no change
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_we |=> $stable(cmp_val[i]));
   end
endmodule

// File: rtl/bpc_addr_match.sv
module bpc_addr_match #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] ref_val,
   input  logic              bus_rd,
   input  logic              q_en,
   input  logic              q_dir,
   output logic              hit
);
   logic dir_ok;
   always_comb begin
      dir_ok = !q_en || (bus_rd == q_dir);
      hit    = dir_ok && (bus_addr == ref_val);
   end
endmodule

// File: rtl/bpc_data_match.sv
module bpc_data_match #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] ref_val,
   input  logic              bus_rd,
   input  logic              want_wr,
   output logic              hit
);
   logic [DATA_W-1:0] seen;
   logic              dir_ok;
   always_comb begin
      seen   = want_wr ? wr_data : rd_data;
      dir_ok = want_wr ? !bus_rd : bus_rd;
      hit    = dir_ok && (seen == ref_val);
   end
endmodule

// File: rtl/bp_cmp_set.sv
module bp_cmp_set
   import bpc_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic [1:0]        mode,
   input  logic [2:0]        rw_en,
   input  logic [2:0]        rw_dir,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_idx,
   input  logic [1:0]        cfg_byte,
   input  logic [7:0]        cfg_wdata,
   input  logic              bus_valid,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] wr_data,
   output logic              match_a,
   output logic              match_b,
   output logic              match_c,
   output logic              match_full
);
   localparam int unsigned NCMP = BPC_NUM_CMP;

   if (DATA_W < 1 || DATA_W > 8) begin : g_bad_data
      $error("bp_cmp_set: DATA_W must lie in 1..8");
   end

   logic [NCMP-1:0][ADDR_W-1:0] cmp_val;
   logic [NCMP-1:0]             addr_hit;
   logic                        data_hit;
   bpc_mode_e                   mode_q;
   logic                        full, a_wants_wr, hit_b, pair_hit, qual;

   bpc_value_regs #(.ADDR_W(ADDR_W), .NUM_CMP(NCMP)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_byte(cfg_byte), .cfg_wdata(cfg_wdata), .cmp_val(cmp_val));

   for (genvar i = 0; i < NCMP; i++) begin : g_addr
      bpc_addr_match #(.ADDR_W(ADDR_W)) u_am (
         .bus_addr(bus_addr), .ref_val(cmp_val[i]), .bus_rd(bus_rd),
         .q_en(rw_en[i]), .q_dir(rw_dir[i]), .hit(addr_hit[i]));
   end

   assign mode_q     = bpc_mode_e'(mode);
   assign full       = bpc_is_full(mode_q);
   assign a_wants_wr = rw_en[0] && !rw_dir[0];

   bpc_data_match #(.DATA_W(DATA_W)) u_dm (
      .rd_data(rd_data), .wr_data(wr_data), .ref_val(cmp_val[1][DATA_W-1:0]),
      .bus_rd(bus_rd), .want_wr(a_wants_wr), .hit(data_hit));

   always_comb begin
      hit_b    = full ? data_hit : addr_hit[1];
      pair_hit = full && addr_hit[0] &&
                 ((mode_q == BPC_A_AND_B) ? data_hit : !data_hit);
      qual     = mod_en && bus_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_a    <= 1'b0;
         match_b    <= 1'b0;
         match_c    <= 1'b0;
         match_full <= 1'b0;
      end else begin
         match_a    <= qual && addr_hit[0];
         match_b    <= qual && hit_b;
         match_c    <= qual && addr_hit[2];
         match_full <= qual && pair_hit;
      end
   end

   p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a || match_b || match_c || match_full) |-> $past(mod_en && bus_valid));
   p_full_has_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match_full |-> match_a);
   p_full_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match_full |-> ($past(mode) == 2'd1 || $past(mode) == 2'd2));
   p_wr_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match_b |-> !($past(mode) inside {2'd1, 2'd2} && $past(rw_en[0]) &&
                    !$past(rw_dir[0]) && $past(bus_rd)));
   p_c_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      match_c |-> ($past(bus_addr) == $past(cmp_val[2])));
endmodule

// File: tb/tb_bp_cmp_set.sv
module tb_bp_cmp_set;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_en = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [2:0]  rw_en = 3'b000, rw_dir = 3'b000;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = 2'd0, cfg_byte = 2'd0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic        bus_valid = 1'b0, bus_rd = 1'b1;
   logic [16:0] bus_addr = '0;
   logic [7:0]  rd_data = 8'h00, wr_data = 8'h00;
   logic        match_a, match_b, match_c, match_full;
   int          total = 0, bad = 0;

   always #5 clk = ~clk;

   bp_cmp_set dut (.*);

   task automatic chk(input string tag, input logic [3:0] exp);
      logic [3:0] got;
      got = {match_full, match_c, match_b, match_a};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got {full,c,b,a}=%b expected %b", tag, got, exp);
      end
   endtask

   task automatic wr_cfg(input logic [1:0] idx, input logic [1:0] b, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_byte = b; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load(input logic [1:0] idx, input logic [16:0] v);
      wr_cfg(idx, 2'd0, {7'd0, v[16]});
      wr_cfg(idx, 2'd1, v[15:8]);
      wr_cfg(idx, 2'd2, v[7:0]);
   endtask

   // one valid bus cycle, then check the pulse in the following cycle
   task automatic cyc(input string tag, input logic [16:0] a, input logic rd,
                      input logic [7:0] rdd, input logic [7:0] wrd, input logic [3:0] exp,
                      input logic vld = 1'b1);
      @(negedge clk);
      bus_valid = vld; bus_addr = a; bus_rd = rd; rd_data = rdd; wr_data = wrd;
      @(posedge clk); #1;
      bus_valid = 1'b0;
      chk(tag, exp);
      @(posedge clk); #1;
      chk({tag, " one-cycle"}, 4'b0000);
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", 4'b0000);
      cyc("R5 mod_en low", 17'h0, 1'b1, 8'h0, 8'h0, 4'b0000);
      mod_en = 1'b1;
      cyc("R1 zero compare values", 17'h0, 1'b1, 8'h0, 8'h0, 4'b0111);
   endtask

   task automatic t_cfg();
      load(2'd0, 17'h12345);
      load(2'd1, 17'h0ABCD);
      load(2'd2, 17'h10010);
      wr_cfg(2'd0, 2'd3, 8'hFF);
      wr_cfg(2'd3, 2'd2, 8'h00);
      cyc("R2 bad codes ignored A", 17'h12345, 1'b1, 8'h0, 8'h0, 4'b0001);
      cyc("R2 ext byte B", 17'h1ABCD, 1'b1, 8'h0, 8'h0, 4'b0000);
   endtask

   task automatic t_normal();
      cyc("R3 B addr", 17'h0ABCD, 1'b1, 8'h0, 8'h0, 4'b0010);
      cyc("R3 C addr", 17'h10010, 1'b0, 8'h0, 8'h0, 4'b0100);
      cyc("R3 ext mismatch", 17'h02345, 1'b1, 8'h0, 8'h0, 4'b0000);
      cyc("R5 no valid", 17'h12345, 1'b1, 8'h0, 8'h0, 4'b0000, 1'b0);
   endtask

   task automatic t_dir();
      rw_en = 3'b001; rw_dir = 3'b000;
      cyc("R4 A write-only sees read", 17'h12345, 1'b1, 8'h0, 8'h0, 4'b0000);
      cyc("R4 A write-only sees write", 17'h12345, 1'b0, 8'h0, 8'h0, 4'b0001);
      rw_en = 3'b100; rw_dir = 3'b100;
      cyc("R4 C read-only sees write", 17'h10010, 1'b0, 8'h0, 8'h0, 4'b0000);
      rw_en = 3'b000; rw_dir = 3'b000;
   endtask

   task automatic t_full_and();
      mode = 2'd1;
      cyc("R6 A and B data hit", 17'h12345, 1'b1, 8'hCD, 8'h00, 4'b1011);
      cyc("R6 data miss", 17'h12345, 1'b1, 8'h11, 8'h00, 4'b0001);
      cyc("R6 B addr ignored", 17'h0ABCD, 1'b1, 8'h00, 8'h00, 4'b0000);
      cyc("R8 B without A", 17'h0ABCD, 1'b1, 8'hCD, 8'h00, 4'b0010);
      rw_en = 3'b001; rw_dir = 3'b000;
      cyc("R7 write data selected", 17'h12345, 1'b0, 8'h00, 8'hCD, 4'b1011);
      cyc("R7 read ignored", 17'h12345, 1'b1, 8'hCD, 8'h00, 4'b0000);
      rw_en = 3'b010; rw_dir = 3'b000;
      cyc("R7 B qualifier ignored", 17'h12345, 1'b1, 8'hCD, 8'hCD, 4'b1011);
      rw_en = 3'b000;
      cyc("R9 C in full mode", 17'h10010, 1'b1, 8'h00, 8'h00, 4'b0100);
   endtask

   task automatic t_full_not();
      mode = 2'd2;
      cyc("R8 A and not B", 17'h12345, 1'b1, 8'h11, 8'h00, 4'b1001);
      cyc("R8 B blocks pair", 17'h12345, 1'b1, 8'hCD, 8'h00, 4'b0011);
      mode = 2'd3;
      cyc("R3 spare code is normal", 17'h0ABCD, 1'b1, 8'hCD, 8'h00, 4'b0010);
      mode = 2'd0;
      cyc("R8 normal no pair", 17'h12345, 1'b1, 8'hCD, 8'h00, 4'b0001);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_cfg();
      t_normal();
      t_dir();
      t_full_and();
      t_full_not();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule